// File: doc/BRIEF.md
# Clamped Three-Channel Color Matrix

This block converts one pixel per cycle from one three-component color space to another. A pixel carries three 10-bit unsigned channels: cr in bits 29:20, yg in bits 19:10 and cb in bits 9:0 of the pixel word. For each channel the block adds a signed input offset and limits the result to a programmable signed window. It then multiplies the three limited values by a 3x3 matrix of signed fixed-point weights. Finally it adds a signed output offset and limits each result to a programmable unsigned 10-bit window.

Settings are written through a single-word write port and land in a pending copy. The pending copy is applied only when `frame_start` pulses. The switch-over moves down the pipeline together with the pixels, so every pixel is converted with one complete set of settings. A pixel is accepted whenever `in_valid` is high. Its result leaves, marked by `out_valid`, a fixed number of cycles later.

Top module: `pmx_csc`

## Requirements
- R1: After reset, `out_valid` and `out_pix` are 0. All weights form the identity matrix (4096 on the diagonal, 0 elsewhere), all offsets are 0, every input window is -1024..1023 and every output window is 0..1023, so a pixel comes out unchanged.
- R2: `out_valid` is high in a cycle exactly when `in_valid` was high 4 cycles earlier, gaps included. `out_pix` carries the result of that same pixel.
- R3: The input offset of channel c is a signed 11-bit value in bits 10:0 of the word at select 5+c (c = 0 cr, 1 yg, 2 cb). It is added to the unsigned input channel before any limiting.
- R4: The input window of channel c is at select 8+c: a signed 11-bit minimum in bits 10:0 and a signed 11-bit maximum in bits 26:16. A value below the minimum becomes the minimum. Otherwise, a value above the maximum becomes the maximum.
- R5: The nine weights are signed 15-bit values with 12 fraction bits. Select s (0..3) holds weight 2s in bits 14:0 and weight 2s+1 in bits 30:16. Select 4 holds weight 8 in bits 14:0. Output channel k sums weight 3k+j times limited input channel j.
- R6: The weighted sum is kept at full precision. It is rounded by adding 2048 and then shifting right arithmetically by 12 bits.
- R7: The output offset of channel c is a signed 11-bit value in bits 26:16 of the word at select 5+c. It is added to the rounded sum before the output window is applied.
- R8: The output window of channel c is at select 11+c: an unsigned 10-bit minimum in bits 9:0 and an unsigned 10-bit maximum in bits 25:16. Any result below the minimum, including a negative one, becomes the minimum. Otherwise, a result above the maximum becomes the maximum.
- R9: A write changes only the pending settings. A pulse on `frame_start` makes the pending settings current. Pixels accepted in the pulse cycle or earlier use the old settings in every stage, and pixels accepted afterwards use the new settings.
- R10: Bits outside the fields named in R3 to R8 are ignored. Writes to selects 14 and 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the settings port |
| cfg_sel | input | 4 | Settings word select (0..13 used) |
| cfg_wdata | input | 32 | Settings word |
| frame_start | input | 1 | Makes the pending settings current |
| in_valid | input | 1 | Input pixel present |
| in_pix | input | 30 | Input pixel, cr 29:20, yg 19:10, cb 9:0 |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 30 | Output pixel, same channel layout |

## Verification
Every pixel result and its `out_valid` are due exactly four rising edges after the edge that samples the pixel. A write changes nothing visible until a later `frame_start`, and its effect shows only in pixels sampled after that pulse. The bench drives on falling edges and keeps a four-deep history of what it drove. At each falling edge it compares `out_valid` and `out_pix` against the oldest entry, so idle cycles are checked as strictly as busy ones. Each expected value is computed from the settings model that was current when the pixel was driven.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
   localparam int NCH     = 3;
   localparam int NCOEF   = NCH * NCH;
   localparam int NPAIR   = NCOEF / 2;
   localparam int NSTG    = 4;
   localparam int HI_LSB  = 16;
   localparam int SEL_W   = 4;
   localparam int SEL_COEF = 0;
   localparam int SEL_OFFS = SEL_COEF + NPAIR + 1;
   localparam int SEL_ICLP = SEL_OFFS + NCH;
   localparam int SEL_OCLP = SEL_ICLP + NCH;
endpackage

// File: rtl/pmx_cfg_regs.sv
module pmx_cfg_regs
   import pmx_pkg::*;
#(
   parameter int PIX_W   = 10,
   parameter int OFF_W   = 11,
   parameter int CF_W    = 15,
   parameter int CF_FRAC = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [SEL_W-1:0]       cfg_sel,
   input  logic [31:0]            cfg_wdata,
   input  logic                   frame_start,
   output logic [NCH*OFF_W-1:0]   s1_ioff,
   output logic [NCH*OFF_W-1:0]   s2_imin,
   output logic [NCH*OFF_W-1:0]   s2_imax,
   output logic [NCOEF*CF_W-1:0]  s3_coef,
   output logic [NCH*OFF_W-1:0]   s4_ooff,
   output logic [NCH*PIX_W-1:0]   s4_omin,
   output logic [NCH*PIX_W-1:0]   s4_omax
);
   localparam int OFS_IOFF = 0;
   localparam int OFS_IMIN = OFS_IOFF + NCH * OFF_W;
   localparam int OFS_IMAX = OFS_IMIN + NCH * OFF_W;
   localparam int OFS_COEF = OFS_IMAX + NCH * OFF_W;
   localparam int OFS_OOFF = OFS_COEF + NCOEF * CF_W;
   localparam int OFS_OMIN = OFS_OOFF + NCH * OFF_W;
   localparam int OFS_OMAX = OFS_OMIN + NCH * PIX_W;
   localparam int TOT      = OFS_OMAX + NCH * PIX_W;

   function automatic logic [TOT-1:0] default_set();
      logic [TOT-1:0] v;
      v = '0;
      for (int c = 0; c < NCH; c++) begin
         v[OFS_IMIN + c*OFF_W +: OFF_W] = {1'b1, {(OFF_W-1){1'b0}}};
         v[OFS_IMAX + c*OFF_W +: OFF_W] = {1'b0, {(OFF_W-1){1'b1}}};
         v[OFS_OMAX + c*PIX_W +: PIX_W] = '1;
         v[OFS_COEF + (c*NCH + c)*CF_W +: CF_W] = CF_W'(1 << CF_FRAC);
      end
      return v;
   endfunction

   localparam logic [TOT-1:0] DEF_SET = default_set();

   logic [TOT-1:0]    pend_q, pend_nx;
   logic [NSTG-2:0]   fs_d;

   always_comb begin
      pend_nx = pend_q;
      if (cfg_we) begin
         for (int s = 0; s < NPAIR; s++) begin
            if (cfg_sel == SEL_W'(SEL_COEF + s)) begin
               pend_nx[OFS_COEF + (2*s)*CF_W   +: CF_W] = cfg_wdata[0 +: CF_W];
               pend_nx[OFS_COEF + (2*s+1)*CF_W +: CF_W] = cfg_wdata[HI_LSB +: CF_W];
            end
         end
         if (cfg_sel == SEL_W'(SEL_COEF + NPAIR))
            pend_nx[OFS_COEF + (NCOEF-1)*CF_W +: CF_W] = cfg_wdata[0 +: CF_W];
         for (int c = 0; c < NCH; c++) begin
            if (cfg_sel == SEL_W'(SEL_OFFS + c)) begin
               pend_nx[OFS_IOFF + c*OFF_W +: OFF_W] = cfg_wdata[0 +: OFF_W];
               pend_nx[OFS_OOFF + c*OFF_W +: OFF_W] = cfg_wdata[HI_LSB +: OFF_W];
            end
            if (cfg_sel == SEL_W'(SEL_ICLP + c)) begin
               pend_nx[OFS_IMIN + c*OFF_W +: OFF_W] = cfg_wdata[0 +: OFF_W];
               pend_nx[OFS_IMAX + c*OFF_W +: OFF_W] = cfg_wdata[HI_LSB +: OFF_W];
            end
            if (cfg_sel == SEL_W'(SEL_OCLP + c)) begin
               pend_nx[OFS_OMIN + c*PIX_W +: PIX_W] = cfg_wdata[0 +: PIX_W];
               pend_nx[OFS_OMAX + c*PIX_W +: PIX_W] = cfg_wdata[HI_LSB +: PIX_W];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= DEF_SET;
         fs_d   <= '0;
      end else begin
         pend_q <= pend_nx;
         fs_d   <= {fs_d[NSTG-3:0], frame_start};
      end
   end

   // One full copy per pipeline stage; the load strobe travels with the pixels.
   for (genvar k = 0; k < NSTG; k++) begin : g_stg
      logic [TOT-1:0] cur;
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cur <= DEF_SET;
            else if (frame_start) cur <= pend_q;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cur <= DEF_SET;
            else if (fs_d[k-1])  cur <= g_stg[k-1].cur;
         end
      end
   end

   assign s1_ioff = g_stg[0].cur[OFS_IOFF +: NCH*OFF_W];
   assign s2_imin = g_stg[1].cur[OFS_IMIN +: NCH*OFF_W];
   assign s2_imax = g_stg[1].cur[OFS_IMAX +: NCH*OFF_W];
   assign s3_coef = g_stg[2].cur[OFS_COEF +: NCOEF*CF_W];
   assign s4_ooff = g_stg[3].cur[OFS_OOFF +: NCH*OFF_W];
   assign s4_omin = g_stg[3].cur[OFS_OMIN +: NCH*PIX_W];
   assign s4_omax = g_stg[3].cur[OFS_OMAX +: NCH*PIX_W];

   // R9: current settings move only on a frame_start pulse
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(g_stg[0].cur));

   // R9: a later stage follows the earlier stage one cycle after its update
   assert_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> ##1 (g_stg[1].cur == $past(g_stg[0].cur)));
endmodule

// File: rtl/pmx_in_chan.sv
module pmx_in_chan #(
   parameter int PIX_W = 10,
   parameter int OFF_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] pix,
   input  logic [OFF_W-1:0] ioff,
   input  logic [OFF_W-1:0] imin,
   input  logic [OFF_W-1:0] imax,
   output logic [OFF_W-1:0] x_o
);
   localparam int SW = OFF_W + 1;

   logic signed [SW-1:0]    sum_q;
   logic signed [SW-1:0]    lo, hi;
   logic signed [OFF_W-1:0] lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= $signed({{(SW-PIX_W){1'b0}}, pix}) + SW'($signed(ioff));
   end

   always_comb begin
      lo = SW'($signed(imin));
      hi = SW'($signed(imax));
      if (sum_q < lo)      lim = $signed(imin);
      else if (sum_q > hi) lim = $signed(imax);
      else                 lim = sum_q[OFF_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) x_o <= '0;
      else        x_o <= lim;
   end

   assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed($past(imin)) <= $signed($past(imax))) |->
         (($signed(x_o) >= $signed($past(imin))) && ($signed(x_o) <= $signed($past(imax)))));
endmodule

// File: rtl/pmx_row_mac.sv
module pmx_row_mac
   import pmx_pkg::*;
#(
   parameter int OFF_W   = 11,
   parameter int CF_W    = 15,
   parameter int CF_FRAC = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCH*OFF_W-1:0]  x_in,
   input  logic [NCH*CF_W-1:0]   w_row,
   output logic [OFF_W+CF_W+2-CF_FRAC-1:0] y_o
);
   localparam int PW = OFF_W + CF_W;
   localparam int SW = PW + 2;
   localparam int RW = SW - CF_FRAC;

   logic signed [PW-1:0] prod [NCH];
   logic signed [SW-1:0] acc;
   logic signed [SW-1:0] rnd;

   always_comb begin
      acc = '0;
      for (int j = 0; j < NCH; j++) begin
         prod[j] = $signed(x_in[j*OFF_W +: OFF_W]) * $signed(w_row[j*CF_W +: CF_W]);
         acc     = acc + SW'(prod[j]);
      end
   end

   if (CF_FRAC > 0) begin : g_round
      assign rnd = acc + SW'(1 << (CF_FRAC - 1));
   end else begin : g_exact
      assign rnd = acc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y_o <= '0;
      else        y_o <= rnd[SW-1:CF_FRAC];
   end
endmodule

// File: rtl/pmx_out_chan.sv
module pmx_out_chan #(
   parameter int PIX_W = 10,
   parameter int OFF_W = 11,
   parameter int RW    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RW-1:0]    y_in,
   input  logic [OFF_W-1:0] ooff,
   input  logic [PIX_W-1:0] omin,
   input  logic [PIX_W-1:0] omax,
   output logic [PIX_W-1:0] z_o
);
   localparam int OW = ((RW > OFF_W) ? RW : OFF_W) + 1;

   logic signed [OW-1:0] sum, lo, hi;
   logic [PIX_W-1:0]     lim;

   always_comb begin
      sum = OW'($signed(y_in)) + OW'($signed(ooff));
      lo  = $signed({{(OW-PIX_W){1'b0}}, omin});
      hi  = $signed({{(OW-PIX_W){1'b0}}, omax});
      if (sum < lo)      lim = omin;
      else if (sum > hi) lim = omax;
      else               lim = sum[PIX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) z_o <= '0;
      else        z_o <= lim;
   end

   assert_out_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(omin) <= $past(omax)) |-> ((z_o >= $past(omin)) && (z_o <= $past(omax))));
endmodule

// File: rtl/pmx_csc.sv
module pmx_csc
   import pmx_pkg::*;
#(
   parameter int PIX_W   = 10,
   parameter int OFF_W   = 11,
   parameter int CF_W    = 15,
   parameter int CF_FRAC = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [SEL_W-1:0]       cfg_sel,
   input  logic [31:0]            cfg_wdata,
   input  logic                   frame_start,
   input  logic                   in_valid,
   input  logic [NCH*PIX_W-1:0]   in_pix,
   output logic                   out_valid,
   output logic [NCH*PIX_W-1:0]   out_pix
);
   localparam int RW = OFF_W + CF_W + 2 - CF_FRAC;

   if (PIX_W < 1 || PIX_W > HI_LSB) begin : g_chk_pix
      $error("pmx_csc: PIX_W must be 1..16");
   end
   if (OFF_W <= PIX_W || OFF_W > HI_LSB) begin : g_chk_off
      $error("pmx_csc: OFF_W must exceed PIX_W and fit 16 bits");
   end
   if (CF_W > HI_LSB - 1 || CF_FRAC >= CF_W) begin : g_chk_cf
      $error("pmx_csc: CF_W must fit 15 bits and exceed CF_FRAC");
   end

   logic [NCH*OFF_W-1:0]  s1_ioff, s2_imin, s2_imax, s4_ooff;
   logic [NCOEF*CF_W-1:0] s3_coef;
   logic [NCH*PIX_W-1:0]  s4_omin, s4_omax;
   logic [NCH*OFF_W-1:0]  x_lim;
   logic [NSTG-1:0]       vld;

   pmx_cfg_regs #(.PIX_W(PIX_W), .OFF_W(OFF_W), .CF_W(CF_W), .CF_FRAC(CF_FRAC)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .frame_start(frame_start),
      .s1_ioff(s1_ioff), .s2_imin(s2_imin), .s2_imax(s2_imax),
      .s3_coef(s3_coef), .s4_ooff(s4_ooff), .s4_omin(s4_omin), .s4_omax(s4_omax)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [RW-1:0] y_row;

      pmx_in_chan #(.PIX_W(PIX_W), .OFF_W(OFF_W)) u_in (
         .clk(clk), .rst_n(rst_n),
         .pix (in_pix[(NCH-1-c)*PIX_W +: PIX_W]),
         .ioff(s1_ioff[c*OFF_W +: OFF_W]),
         .imin(s2_imin[c*OFF_W +: OFF_W]),
         .imax(s2_imax[c*OFF_W +: OFF_W]),
         .x_o (x_lim[c*OFF_W +: OFF_W])
      );

      pmx_row_mac #(.OFF_W(OFF_W), .CF_W(CF_W), .CF_FRAC(CF_FRAC)) u_mac (
         .clk(clk), .rst_n(rst_n),
         .x_in (x_lim),
         .w_row(s3_coef[c*NCH*CF_W +: NCH*CF_W]),
         .y_o  (y_row)
      );

      pmx_out_chan #(.PIX_W(PIX_W), .OFF_W(OFF_W), .RW(RW)) u_out (
         .clk(clk), .rst_n(rst_n),
         .y_in(y_row),
         .ooff(s4_ooff[c*OFF_W +: OFF_W]),
         .omin(s4_omin[c*PIX_W +: PIX_W]),
         .omax(s4_omax[c*PIX_W +: PIX_W]),
         .z_o (out_pix[(NCH-1-c)*PIX_W +: PIX_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= '0;
      else        vld <= {vld[NSTG-2:0], in_valid};
   end

   assign out_valid = vld[NSTG-1];

   assert_lat_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##3 out_valid);

   assert_lat_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##3 !out_valid);
endmodule

// File: tb/sim_pmx_csc.sv
module sim_pmx_csc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        frame_start = 1'b0;
   logic        in_valid = 1'b0;
   logic [29:0] in_pix = '0;
   logic        out_valid;
   logic [29:0] out_pix;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   string tag = "R1";

   int p_coef[9], p_ioff[3], p_ooff[3], p_imin[3], p_imax[3], p_omin[3], p_omax[3];
   int a_coef[9], a_ioff[3], a_ooff[3], a_imin[3], a_imax[3], a_omin[3], a_omax[3];

   bit          hv[4];
   logic [29:0] hp[4];
   string       hr[4];

   always #2 clk = ~clk;

   pmx_csc u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
      .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
   );

   function automatic int sx(int v, int w);
      return (v >= (1 << (w-1))) ? v - (1 << w) : v;
   endfunction

   function automatic logic [31:0] pk(int lo, int hi);
      logic [31:0] r;
      r[15:0]  = 16'(lo);
      r[31:16] = 16'(hi);
      return r;
   endfunction

   function automatic logic [29:0] ref_pix(logic [29:0] p);
      int x[3];
      logic [29:0] o;
      for (int j = 0; j < 3; j++) begin
         x[j] = int'(p[(2-j)*10 +: 10]) + a_ioff[j];
         if (x[j] < a_imin[j]) x[j] = a_imin[j];
         else if (x[j] > a_imax[j]) x[j] = a_imax[j];
      end
      for (int k = 0; k < 3; k++) begin
         int acc, y;
         acc = 0;
         for (int j = 0; j < 3; j++) acc += a_coef[3*k+j] * x[j];
         y = ((acc + 2048) >>> 12) + a_ooff[k];
         if (y < a_omin[k]) y = a_omin[k];
         else if (y > a_omax[k]) y = a_omax[k];
         o[(2-k)*10 +: 10] = 10'(y);
      end
      return o;
   endfunction

   task automatic mdl_reset();
      for (int i = 0; i < 9; i++) p_coef[i] = (i % 4 == 0) ? 4096 : 0;
      for (int c = 0; c < 3; c++) begin
         p_ioff[c] = 0; p_ooff[c] = 0; p_imin[c] = -1024; p_imax[c] = 1023;
         p_omin[c] = 0; p_omax[c] = 1023;
      end
      a_coef = p_coef; a_ioff = p_ioff; a_ooff = p_ooff; a_imin = p_imin;
      a_imax = p_imax; a_omin = p_omin; a_omax = p_omax;
   endtask

   task automatic mdl_write(int sel, logic [31:0] d);
      if (sel < 4) begin
         p_coef[2*sel] = sx(int'(d[14:0]), 15); p_coef[2*sel+1] = sx(int'(d[30:16]), 15);
      end else if (sel == 4) p_coef[8] = sx(int'(d[14:0]), 15);
      else if (sel < 8) begin
         p_ioff[sel-5] = sx(int'(d[10:0]), 11); p_ooff[sel-5] = sx(int'(d[26:16]), 11);
      end else if (sel < 11) begin
         p_imin[sel-8] = sx(int'(d[10:0]), 11); p_imax[sel-8] = sx(int'(d[26:16]), 11);
      end else if (sel < 14) begin
         p_omin[sel-11] = int'(d[9:0]); p_omax[sel-11] = int'(d[25:16]);
      end
   endtask

   task automatic cycle(bit v, logic [29:0] pix, bit fs, bit we, int sel, logic [31:0] d);
      @(negedge clk);
      n_chk++;
      if (out_valid !== hv[3]) begin
         n_bad++;
         $display("FAIL %s out_valid actual=%0b expected=%0b", hr[3], out_valid, hv[3]);
      end
      if (hv[3]) begin
         n_chk++;
         if (out_pix !== hp[3]) begin
            n_bad++;
            $display("FAIL %s out_pix actual=%h expected=%h", hr[3], out_pix, hp[3]);
         end
      end
      for (int i = 3; i > 0; i--) begin hv[i] = hv[i-1]; hp[i] = hp[i-1]; hr[i] = hr[i-1]; end
      hv[0] = v; hp[0] = v ? ref_pix(pix) : '0; hr[0] = (tag == "R1") ? "R2" : tag;
      in_valid = v; in_pix = pix; frame_start = fs; cfg_we = we;
      cfg_sel = 4'(sel); cfg_wdata = d;
      if (fs) begin
         a_coef = p_coef; a_ioff = p_ioff; a_ooff = p_ooff; a_imin = p_imin;
         a_imax = p_imax; a_omin = p_omin; a_omax = p_omax;
      end
      if (we) mdl_write(sel, d);
   endtask

   task automatic wr(int sel, logic [31:0] d); cycle(0, '0, 0, 1, sel, d); endtask
   task automatic fs(); cycle(0, '0, 1, 0, 0, '0); endtask
   task automatic px(logic [29:0] p); cycle(1, p, 0, 0, 0, '0); endtask
   task automatic idle(int n); for (int i = 0; i < n; i++) cycle(0, '0, 0, 0, 0, '0); endtask
   function automatic logic [29:0] mk(int a, int b, int c);
      return {10'(a), 10'(b), 10'(c)};
   endfunction

   task automatic restore();
      for (int s = 0; s < 4; s++) wr(s, pk((s == 0) ? 4096 : 0, (s == 2) ? 4096 : 0));
      wr(4, pk(4096, 0));
      for (int c = 0; c < 3; c++) begin
         wr(5 + c, 0); wr(8 + c, pk(-1024, 1023)); wr(11 + c, pk(0, 1023));
      end
      fs();
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      mdl_reset();
      for (int i = 0; i < 4; i++) begin hv[i] = 0; hp[i] = '0; hr[i] = "R2"; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      n_chk++;
      if (out_valid !== 1'b0 || out_pix !== '0) begin
         n_bad++;
         $display("FAIL R1 reset outputs actual=%0b/%h expected=0/0", out_valid, out_pix);
      end
      // R1: default settings pass pixels unchanged
      tag = "R1";
      px(mk(0, 0, 0)); px(mk(1023, 1023, 1023)); px(mk(1, 512, 1022));
      for (int i = 0; i < 20; i++) px(30'($urandom));
      idle(5);
      // R2: gaps in the valid pattern
      tag = "R2";
      for (int i = 0; i < 60; i++) cycle($urandom % 3 != 0, 30'($urandom), 0, 0, 0, '0);
      idle(5);
      // R9: a write alone changes nothing; pulse-cycle pixel keeps the old set
      tag = "R9";
      wr(0, pk(2048, 0));
      px(mk(400, 300, 200));
      cycle(1, mk(400, 300, 200), 1, 0, 0, '0);
      px(mk(400, 300, 200));
      cycle(1, mk(800, 10, 10), 1, 1, 0, pk(4096, 0));
      px(mk(800, 10, 10));
      idle(5);
      // R5: full matrix with cross terms and the lone ninth weight
      tag = "R5";
      wr(0, pk(1024, 2048)); wr(1, pk(-1024, 0)); wr(2, pk(4096, 512));
      wr(3, pk(-4096, 8192)); wr(4, pk(-512, 0)); fs();
      px(mk(100, 200, 300)); px(mk(1023, 0, 511)); px(mk(7, 900, 1000));
      idle(5); restore();
      // R3: signed input offsets with open windows
      tag = "R3";
      wr(5, pk(-100, 0)); wr(6, pk(600, 0)); wr(7, pk(-1024, 0)); fs();
      px(mk(50, 1000, 1023)); px(mk(500, 0, 0));
      idle(5); restore();
      // R4: narrow, crossed and boundary input windows
      tag = "R4";
      wr(8, pk(100, 200)); wr(9, pk(300, 250)); wr(10, pk(-5, 0)); wr(7, pk(-600, 0)); fs();
      px(mk(99, 0, 700)); px(mk(201, 1023, 595)); px(mk(150, 260, 0)); px(mk(100, 300, 1023));
      idle(5); restore();
      // R6: rounding half up, including negative halves
      tag = "R6";
      wr(0, pk(2048, 0)); wr(2, pk(-2048, 0)); wr(4, pk(2049, 0));
      wr(6, pk(0, 5)); wr(5, pk(0, 1)); fs();
      px(mk(1, 1, 1)); px(mk(3, 3, 3)); px(mk(2, 5, 7));
      idle(5); restore();
      // R7: output offsets applied after rounding
      tag = "R7";
      wr(5, pk(0, -30)); wr(6, pk(0, 1000)); wr(7, pk(0, 17)); fs();
      px(mk(100, 20, 1000)); px(mk(10, 500, 0));
      idle(5); restore();
      // R8: output windows with negative and too-large results
      tag = "R8";
      wr(0, pk(-4096, 0)); wr(11, pk(7, 1000)); wr(12, pk(100, 400)); wr(13, pk(600, 500)); fs();
      px(mk(100, 50, 300)); px(mk(0, 900, 700)); px(mk(0, 250, 550));
      idle(5); restore();
      // R10: bits outside fields and unused selects are ignored
      tag = "R10";
      wr(5, 32'hF800_F805); wr(14, 32'hFFFF_FFFF); wr(15, 32'h1234_5678);
      wr(4, 32'hFFFF_9000); wr(11, 32'hFC14_FC0A); fs();
      px(mk(0, 20, 30)); px(mk(1023, 1023, 1023)); px(mk(300, 2, 1));
      idle(5); restore();
      // R5: random settings, random pixels, occasional pulses mid-stream
      tag = "R5";
      for (int r = 0; r < 40; r++) begin
         for (int s = 0; s < 14; s++) begin
            logic [31:0] d;
            d = $urandom;
            if (s < 5 && ($urandom % 2 == 0)) d = pk(int'($urandom % 8192) - 4096, int'($urandom % 8192) - 4096);
            if (s >= 8 && s < 11 && ($urandom % 2 == 0)) d = pk(-1024, 1023);
            wr(s, d);
         end
         for (int i = 0; i < 40; i++)
            cycle($urandom % 4 != 0, 30'($urandom), ($urandom % 16 == 0), 0, 0, '0);
      end
      idle(6);
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule